// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a small word-addressed memory and serves several requesters that share it. Each requester presents an opcode, a word address and up to two operands. The unit can run a plain load, a plain store, a swap, a test-and-set, a compare-and-swap or a fetch-and-increment. Every operation runs as one unbreakable sequence: a read phase and then a write phase. No other access can land on the memory between those two phases. The response always carries the word as it was before the operation. For compare-and-swap it also carries a match flag.

When several requesters are valid in the idle cycle, a round-robin arbiter grants one of them. The others keep their request raised and are served in later turns. A requester holds its valid and fields until it sees its ready bit. The handshake completes on the clock edge that ends the write phase, and that same edge commits the write. Software uses the unit for spinlocks and counters. A lock is taken by test-and-set or compare-and-swap and released by a plain store of 0.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every memory word reads 0, every ready bit is low and rsp_valid_o is low.
- R2: A request that is valid while the unit is idle gets its ready bit, together with rsp_valid_o, in the second cycle after that idle cycle. Ready is high for exactly one cycle, at most one ready bit is high at a time, rsp_id_o names the granted requester, and at least one idle cycle follows each response.
- R3: Opcode 0 (load) returns the word and leaves it unchanged. Opcode 1 (store) writes operand A and returns the old word.
- R4: Opcode 2 (swap) writes operand A to the word and returns the previous value.
- R5: Opcode 3 (test-and-set) returns the previous word and always writes 1. A later store of 0 makes the next test-and-set on that word return 0.
- R6: Opcode 4 (compare-and-swap) writes operand B only when the stored word equals operand A, and raises rsp_ok_o in that case. On a mismatch the word is left unchanged and rsp_ok_o is 0. The old word is returned in both cases.
- R7: Opcode 5 (fetch-and-increment) returns the old word and stores the old word plus one, modulo 2^DATA_W.
- R8: Among the valid requesters, the grant goes to the first one found searching upward, with wrap-around, from the round-robin pointer. The pointer is 0 after reset and moves to one past each requester served. A requester that is not granted keeps its request pending.
- R9: When all requesters run test-and-set on the same free word at once, exactly one of them receives 0 and all the others receive 1.
- R10: Opcodes 6 and 7 return the old word, write nothing and give rsp_ok_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request valid, one bit per requester |
| req_ready_o | output | N_REQ | Completion handshake, one bit per requester |
| req_op_i | input | N_REQ x 3 | Opcode of each requester |
| req_addr_i | input | N_REQ x ADDR_W | Word address of each requester |
| req_opa_i | input | N_REQ x DATA_W | Operand A (store/swap data, compare value) |
| req_opb_i | input | N_REQ x DATA_W | Operand B (compare-and-swap new value) |
| rsp_valid_o | output | 1 | Response valid in the write phase |
| rsp_id_o | output | IDX_W | Index of the requester being answered |
| rsp_data_o | output | DATA_W | Word before the operation |
| rsp_ok_o | output | 1 | Compare-and-swap matched |

## Verification
All results are due in the write phase. Counting from the idle cycle in which a request is seen, that is two clock edges later: the first edge captures the grant, and the second latches the old word. The memory update becomes visible at the edge that ends the write phase. The bench therefore drives and samples on falling edges, and counts those falling edges from the one where valid is raised. It requires ready at exactly the second one and reads the response there. Written values are checked by a later load, which is a full operation of its own. Under contention, each loser's valid stays high until its own ready appears, and the order of those ready bits is compared against a pointer model kept in the bench.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_SWAP  = 3'd2;
  localparam logic [2:0] OP_TAS   = 3'd3;
  localparam logic [2:0] OP_CAS   = 3'd4;
  localparam logic [2:0] OP_FAI   = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } rmw_state_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] done_idx_i,
  output logic             any_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    any_o     = 1'b0;
    gnt_idx_o = '0;
    for (int off = 0; off < N_REQ; off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (!any_o && req_i[idx]) begin
        any_o     = 1'b1;
        gnt_idx_o = IDX_W'(idx);
      end
    end
  end

  // pointer moves one past the requester just served
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv_i) begin
      if (int'(done_idx_i) == N_REQ - 1) ptr_q <= '0;
      else                               ptr_q <= done_idx_i + IDX_W'(1);
    end
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ok_o
);
  always_comb begin
    wr_en_o   = 1'b0;
    wr_data_o = old_i;
    ok_o      = 1'b0;
    case (op_i)
      OP_STORE, OP_SWAP: begin
        wr_en_o   = 1'b1;
        wr_data_o = opa_i;
      end
      OP_TAS: begin
        wr_en_o   = 1'b1;
        wr_data_o = DATA_W'(1);
      end
      OP_CAS: begin
        ok_o      = (old_i == opa_i);
        wr_en_o   = ok_o;
        wr_data_o = opb_i;
      end
      OP_FAI: begin
        wr_en_o   = 1'b1;
        wr_data_o = old_i + DATA_W'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DEPTH-1:0][DATA_W-1:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  words[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))     words[g] <= wdata_i;
    end
  end

  assign rdata_o = words[raddr_i];
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_valid_i,
  output logic [N_REQ-1:0]              req_ready_o,
  input  logic [N_REQ-1:0][2:0]         req_op_i,
  input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_opa_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_opb_i,
  output logic                          rsp_valid_o,
  output logic [IDX_W-1:0]              rsp_id_o,
  output logic [DATA_W-1:0]             rsp_data_o,
  output logic                          rsp_ok_o
);
  rmw_state_e        st_q;
  logic [IDX_W-1:0]  gnt_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q;

  logic              arb_any;
  logic [IDX_W-1:0]  arb_idx;
  logic [DATA_W-1:0] mem_rdata, alu_wdata;
  logic              alu_we, alu_ok, in_wr;

  assign in_wr = (st_q == ST_WR);

  rr_arbiter #(.N_REQ(N_REQ)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_valid_i),
    .adv_i      (in_wr),
    .done_idx_i (gnt_q),
    .any_o      (arb_any),
    .gnt_idx_o  (arb_idx)
  );

  word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (in_wr && alu_we),
    .waddr_i (addr_q),
    .wdata_i (alu_wdata),
    .raddr_i (addr_q),
    .rdata_o (mem_rdata)
  );

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op_q),
    .old_i     (old_q),
    .opa_i     (opa_q),
    .opb_i     (opb_q),
    .wr_en_o   (alu_we),
    .wr_data_o (alu_wdata),
    .ok_o      (alu_ok)
  );

  // idle -> read -> write; memory is touched only by the granted request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      gnt_q  <= '0;
      op_q   <= '0;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      old_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (arb_any) begin
          st_q   <= ST_RD;
          gnt_q  <= arb_idx;
          op_q   <= req_op_i[arb_idx];
          addr_q <= req_addr_i[arb_idx];
          opa_q  <= req_opa_i[arb_idx];
          opb_q  <= req_opb_i[arb_idx];
        end
        ST_RD: begin
          old_q <= mem_rdata;
          st_q  <= ST_WR;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready_o = '0;
    if (in_wr) req_ready_o[gnt_q] = 1'b1;
  end

  assign rsp_valid_o = in_wr;
  assign rsp_id_o    = gnt_q;
  assign rsp_data_o  = old_q;
  assign rsp_ok_o    = in_wr && alu_ok;
endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_ok_o
);
  // R2
  ready_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  // R8
  ready_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  // R2
  rsp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R6
  ok_in_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok_o |-> rsp_valid_o);
  // R2
  ready_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |=> (req_ready_o == '0));
endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ok_o    (rsp_ok_o)
);

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         valid = '0;
  logic [N-1:0]         ready;
  logic [N-1:0][2:0]    op = '0;
  logic [N-1:0][AW-1:0] addr = '0;
  logic [N-1:0][DW-1:0] opa = '0;
  logic [N-1:0][DW-1:0] opb = '0;
  logic                 rsp_valid, rsp_ok;
  logic [IW-1:0]        rsp_id;
  logic [DW-1:0]        rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  int ptr_m = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  atomic_rmw_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(op), .req_addr_i(addr), .req_opa_i(opa), .req_opb_i(opb),
    .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id),
    .rsp_data_o(rsp_data), .rsp_ok_o(rsp_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one full operation on requester id; returns old word, ok flag and latency
  task automatic do_op(input int id, input logic [2:0] o, input logic [AW-1:0] a,
                       input logic [DW-1:0] x, input logic [DW-1:0] y,
                       output logic [DW-1:0] rd, output logic ok, output int lat);
    @(negedge clk);
    op[id] = o; addr[id] = a; opa[id] = x; opb[id] = y; valid[id] = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready[id] && lat < 50);
    rd = rsp_data;
    ok = rsp_ok;
    check("R2 rsp_id", 32'(rsp_id), 32'(id));
    check("R2 ready onehot", 32'(ready), 32'(1 << id));
    ptr_m = (id + 1) % N;
    @(negedge clk);
    valid[id] = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; logic ok; int lat;
    check("R1 ready after reset", 32'(ready), 0);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 0);
    do_op(0, 3'd0, 4'd9, '0, '0, rd, ok, lat);
    check("R1 word after reset", 32'(rd), 0);
    check("R2 latency", 32'(lat), 2);
    @(negedge clk);
    check("R2 ready drops", 32'(ready), 0);
  endtask

  task automatic t_load_store();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(1, 3'd1, 4'd2, 16'hBEEF, '0, rd, ok, lat);
    check("R3 store returns old", 32'(rd), 0);
    do_op(2, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R3 load sees store", 32'(rd), 32'h0000BEEF);
    do_op(3, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R3 load leaves word", 32'(rd), 32'h0000BEEF);
    check("R2 latency", 32'(lat), 2);
  endtask

  task automatic t_swap();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(0, 3'd2, 4'd2, 16'h1234, '0, rd, ok, lat);
    check("R4 swap returns old", 32'(rd), 32'h0000BEEF);
    do_op(1, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R4 swap wrote", 32'(rd), 32'h00001234);
  endtask

  task automatic t_tas();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(0, 3'd3, 4'd7, '0, '0, rd, ok, lat);
    check("R5 tas on free lock", 32'(rd), 0);
    do_op(1, 3'd3, 4'd7, '0, '0, rd, ok, lat);
    check("R5 tas on held lock", 32'(rd), 1);
    do_op(2, 3'd1, 4'd7, '0, '0, rd, ok, lat);
    do_op(3, 3'd3, 4'd7, '0, '0, rd, ok, lat);
    check("R5 tas after release", 32'(rd), 0);
    do_op(0, 3'd1, 4'd7, '0, '0, rd, ok, lat);
  endtask

  task automatic t_cas();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(0, 3'd4, 4'd2, 16'h1111, 16'h5555, rd, ok, lat);
    check("R6 cas miss old", 32'(rd), 32'h00001234);
    check("R6 cas miss ok", 32'(ok), 0);
    do_op(1, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R6 cas miss no write", 32'(rd), 32'h00001234);
    do_op(2, 3'd4, 4'd2, 16'h1234, 16'h5555, rd, ok, lat);
    check("R6 cas hit old", 32'(rd), 32'h00001234);
    check("R6 cas hit ok", 32'(ok), 1);
    do_op(3, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R6 cas hit wrote", 32'(rd), 32'h00005555);
  endtask

  task automatic t_fai();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(0, 3'd1, 4'd4, 16'hFFFE, '0, rd, ok, lat);
    do_op(1, 3'd5, 4'd4, '0, '0, rd, ok, lat);
    check("R7 fai old", 32'(rd), 32'h0000FFFE);
    do_op(2, 3'd5, 4'd4, '0, '0, rd, ok, lat);
    check("R7 fai old before wrap", 32'(rd), 32'h0000FFFF);
    do_op(3, 3'd0, 4'd4, '0, '0, rd, ok, lat);
    check("R7 fai wraps to 0", 32'(rd), 0);
  endtask

  task automatic t_bad_op();
    logic [DW-1:0] rd; logic ok; int lat;
    do_op(0, 3'd6, 4'd2, 16'h5555, 16'h7777, rd, ok, lat);
    check("R10 op6 returns old", 32'(rd), 32'h00005555);
    check("R10 op6 ok", 32'(ok), 0);
    do_op(1, 3'd7, 4'd2, 16'h9999, 16'h7777, rd, ok, lat);
    check("R10 op7 ok", 32'(ok), 0);
    do_op(2, 3'd0, 4'd2, '0, '0, rd, ok, lat);
    check("R10 no write", 32'(rd), 32'h00005555);
  endtask

  // all requesters race test-and-set on one free word
  task automatic t_contend(input int first_idle);
    int wins = 0;
    logic [N-1:0] pend;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      op[i] = 3'd3; addr[i] = 4'd11; opa[i] = '0; opb[i] = '0;
    end
    valid = '1;
    pend = '1;
    for (int k = 0; k < N; k++) begin
      int cyc = 0;
      int exp_id = -1;
      int got = -1;
      for (int s = 0; s < N; s++) begin
        int j = (ptr_m + s) % N;
        if (exp_id < 0 && pend[j]) exp_id = j;
      end
      do begin
        @(negedge clk);
        cyc++;
      end while (ready == '0 && cyc < 50);
      for (int i = 0; i < N; i++) if (ready[i]) got = i;
      check("R8 rr grant order", 32'(got), 32'(exp_id));
      check("R8 losers still pending", 32'(valid), 32'(pend));
      if (rsp_data == '0) wins++;
      check("R9 tas result", 32'(rsp_data), (k == 0) ? 0 : 1);
      if (got >= 0) begin
        ptr_m = (got + 1) % N;
        @(negedge clk);
        valid[got] = 1'b0;
        pend[got] = 1'b0;
      end
    end
    check("R9 single winner", 32'(wins), 1);
    if (first_idle == 0) ptr_m = ptr_m;
  endtask

  task automatic t_rr_partial();
    // requesters 0 and 2 compete after pointer sits at 1
    logic [DW-1:0] rd; logic ok; int lat; int got;
    do_op(0, 3'd0, 4'd0, '0, '0, rd, ok, lat); // pointer -> 1
    @(negedge clk);
    op[0] = 3'd5; addr[0] = 4'd12; op[2] = 3'd5; addr[2] = 4'd12;
    valid[0] = 1'b1; valid[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    got = -1;
    for (int i = 0; i < N; i++) if (ready[i]) got = i;
    check("R8 skips to first valid at pointer", 32'(got), 2);
    check("R7 first fai old", 32'(rsp_data), 0);
    @(negedge clk);
    valid[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 wrap grants 0", 32'(ready), 1);
    check("R7 second fai old", 32'(rsp_data), 1);
    ptr_m = 1;
    @(negedge clk);
    valid[0] = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_store();
    t_swap();
    t_tas();
    t_cas();
    t_fai();
    t_bad_op();
    t_contend(0);
    t_rr_partial();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule